// File: doc/BRIEF.md
# Two-Channel Converter Serial Port Model

This block is a synthesizable stand-in for the digital side of a 16-bit, two-input sampling converter. It acts as the device end of a four-wire serial link: a host controller drives a convert strobe, a shift clock and a data-in line, and the model answers on a data-out line that it can release to high impedance. A host controller under test can run against it in simulation or on a prototype, and the model reports the protocol mistakes that such a controller can make.

All port inputs are sampled on the system clock `clk`, so the host's strobe and shift clock must be slow against it. A rising strobe samples the two digital channel inputs using the pending multiplexer setting and starts a conversion timer. If the strobe is still high when the timer runs out, the result is kept and the port goes to sleep. When the strobe goes low, the port drives the result MSB first. In the same frame it takes in the multiplexer setting for the next conversion. A strobe that drops before the timer runs out aborts the conversion, and that frame carries an invalid, all-zero word.

Top module: `adc_serial_model`

## Requirements
- R1: `sdo_en_o` is 0 while the strobe is high and 1 while it is low, one `clk` cycle after the strobe level is sampled.
- R2: A rising strobe raises `busy_o` for CONV_CYCLES clock cycles. If the strobe is still high when that time ends, `busy_o` falls, `sleep_o` rises and the result is held. `sleep_o` clears at the next strobe fall.
- R3: A strobe fall while `busy_o` is high ends the conversion at once. `busy_o` drops, `word_invalid_o` is 1 for that frame and the frame shifts out 0x0000. `word_invalid_o` returns to 0 at a strobe fall that follows a completed conversion.
- R4: The first two data-in bits, taken on shift-clock rises after a strobe fall, form the pending setting. Bit one selects single-ended (1) or differential (0) mode. Bit two is the odd/sign select. The setting takes effect at the next strobe rise, and later data-in bits in the frame are ignored.
- R5: Result bit 15 is on `sdo_o` from the strobe fall onward, and each shift-clock fall moves the next lower bit onto `sdo_o`.
- R6: After the 16th shift-clock fall of a frame, `sdo_o` stays 0 for any further shift clocks while the strobe is low.
- R7: Single-ended mode converts input 0 (select 0) or input 1 (select 1). Differential mode converts input 0 minus input 1 (select 0) or input 1 minus input 0 (select 1). A negative difference gives 0x0000, and a full-span difference gives 0xFFFF.
- R8: `proto_err_o` sets at a strobe rise that ends a frame with fewer than 16 shift-clock rises. It also sets on any shift-clock rise while the strobe is high. It clears at the next strobe fall.
- R9: After reset the pending setting is single-ended input 0 and the held result is 0x0000. `busy_o`, `sleep_o`, `word_invalid_o`, `proto_err_o` and `sdo_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert strobe from the host |
| sck_i | input | 1 | Shift clock from the host |
| sdi_i | input | 1 | Serial configuration data from the host |
| ain0_i | input | DATA_W | Digital value presented on input 0 |
| ain1_i | input | DATA_W | Digital value presented on input 1 |
| sdo_o | output | 1 | Serial result data |
| sdo_en_o | output | 1 | Drive enable for `sdo_o` (0 means high impedance) |
| busy_o | output | 1 | Conversion timer running |
| sleep_o | output | 1 | Conversion finished with the strobe still high |
| word_invalid_o | output | 1 | The word of the current frame comes from an aborted conversion |
| proto_err_o | output | 1 | Host protocol error seen |

## Verification
The hardest case to reach from the ports is an abort: the strobe has to fall inside the conversion window and not after it. The next frame must then still load its setting while shifting zeros and flagging the word. The stimulus holds the strobe high for only a few cycles, well short of CONV_CYCLES. It then runs a normal conversion to show that the invalid flag clears and the setting from the aborted frame was applied. Short frames and a shift clock pulsed while the strobe is high are driven on purpose between randomly configured full frames. Some of those full frames carry extra clocks to exercise the zero tail.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

   typedef struct packed {
      logic single;
      logic odd;
   } mux_cfg_t;

   localparam int       CFG_W     = $bits(mux_cfg_t);
   localparam mux_cfg_t CFG_RESET = '{single: 1'b1, odd: 1'b0};

endpackage

// File: rtl/adc_mux_calc.sv
module adc_mux_calc
   import adc_port_pkg::*;
#(
   parameter int W = 16
) (
   input  mux_cfg_t       cfg_i,
   input  logic [W-1:0]   ain0_i,
   input  logic [W-1:0]   ain1_i,
   output logic [W-1:0]   code_o
);

   logic [W-1:0] plus_v;
   logic [W-1:0] minus_v;

   always_comb begin
      plus_v  = cfg_i.odd ? ain1_i : ain0_i;
      minus_v = cfg_i.odd ? ain0_i : ain1_i;
      if (cfg_i.single) begin
         code_o = plus_v;
      end else if (plus_v >= minus_v) begin
         code_o = plus_v - minus_v;
      end else begin
         code_o = '0;
      end
   end

   // R7
   always_comb begin
      if (!cfg_i.single && (plus_v < minus_v)) begin
         clamp_chk: assert (code_o == '0);
      end
   end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic fin_o
);

   localparam int            CW   = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("adc_conv_timer: CYCLES must be at least 2");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         if (cnt_q == ONE) begin
            busy_q <= 1'b0;
         end
         cnt_q <= cnt_q - ONE;
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = busy_q && (cnt_q == ONE) && !abort_i && !start_i;

   // R2
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (cnt_q > ONE) && !abort_i && !start_i) |=> busy_q);

endmodule

// File: rtl/adc_shift_port.sv
module adc_shift_port
   import adc_port_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         conv_i,
   input  logic         conv_rise_i,
   input  logic         conv_fall_i,
   input  logic         sck_i,
   input  logic         sdi_i,
   input  logic [W-1:0] load_i,
   output logic         sdo_o,
   output logic         sdo_en_o,
   output mux_cfg_t     cfg_o,
   output logic         short_o,
   output logic         hi_clk_o
);

   localparam int                 CNT_W    = $clog2(W + 1);
   localparam logic [CNT_W-1:0]   CNT_MAX  = CNT_W'(W);
   localparam logic [CFG_W-1:0]   CFG_INIT = CFG_RESET;

   if (W < CFG_W + 2) begin : g_bad_width
      $error("adc_shift_port: word too narrow for the configuration field");
   end

   logic             sck_q;
   logic             frame_q;
   logic             en_q;
   logic [W-1:0]     sh_q;
   logic [CNT_W-1:0] rcnt_q;
   logic [CFG_W-1:0] cfg_bits;
   logic             sck_rise;
   logic             sck_fall;
   logic             cap_en;

   assign sck_rise = sck_i & ~sck_q;
   assign sck_fall = ~sck_i & sck_q;
   assign cap_en   = frame_q & sck_rise & ~conv_rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         en_q    <= 1'b0;
         frame_q <= 1'b0;
      end else begin
         sck_q <= sck_i;
         en_q  <= ~conv_i;
         if (conv_fall_i) begin
            frame_q <= 1'b1;
         end else if (conv_rise_i) begin
            frame_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rcnt_q <= '0;
      end else if (conv_fall_i) begin
         sh_q   <= load_i;
         rcnt_q <= '0;
      end else begin
         if (frame_q && sck_fall) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
         end
         if (cap_en && (rcnt_q != CNT_MAX)) begin
            rcnt_q <= rcnt_q + CNT_W'(1);
         end
      end
   end

   for (genvar gi = 0; gi < CFG_W; gi++) begin : g_cap
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= CFG_INIT[CFG_W-1-gi];
         end else if (cap_en && (rcnt_q == CNT_W'(gi))) begin
            bit_q <= sdi_i;
         end
      end
      assign cfg_bits[CFG_W-1-gi] = bit_q;
   end

   assign cfg_o    = mux_cfg_t'(cfg_bits);
   assign sdo_o    = sh_q[W-1];
   assign sdo_en_o = en_q;
   assign short_o  = conv_rise_i & frame_q & (rcnt_q != CNT_MAX);
   assign hi_clk_o = sck_rise & conv_i;

   // R6
   zero_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_q && (rcnt_q == CNT_MAX) && sck_fall && !conv_fall_i) |=> (sh_q == '0));

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcnt_q >= CNT_W'(CFG_W)) |=> $stable(cfg_bits));

endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model
   import adc_port_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] ain0_i,
   input  logic [DATA_W-1:0] ain1_i,
   output logic              sdo_o,
   output logic              sdo_en_o,
   output logic              busy_o,
   output logic              sleep_o,
   output logic              word_invalid_o,
   output logic              proto_err_o
);

   if (DATA_W < 4) begin : g_bad_data_w
      $error("adc_serial_model: DATA_W must be at least 4");
   end

   logic              conv_q;
   logic              conv_rise;
   logic              conv_fall;
   logic              busy;
   logic              fin;
   logic              abort_now;
   logic              short_frame;
   logic              hi_clk;
   mux_cfg_t          cfg_pend;
   logic [DATA_W-1:0] code;
   logic [DATA_W-1:0] held_q;
   logic [DATA_W-1:0] result_q;
   logic [DATA_W-1:0] load_word;
   logic              sleep_q;
   logic              inval_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conv_q <= 1'b0;
      else        conv_q <= conv_i;
   end

   assign conv_rise = conv_i & ~conv_q;
   assign conv_fall = ~conv_i & conv_q;
   assign abort_now = conv_fall & busy;

   adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (conv_rise),
      .abort_i (conv_fall),
      .busy_o  (busy),
      .fin_o   (fin)
   );

   adc_mux_calc #(.W(DATA_W)) u_mux (
      .cfg_i  (cfg_pend),
      .ain0_i (ain0_i),
      .ain1_i (ain1_i),
      .code_o (code)
   );

   assign load_word = abort_now ? '0 : result_q;

   adc_shift_port #(.W(DATA_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_i      (conv_i),
      .conv_rise_i (conv_rise),
      .conv_fall_i (conv_fall),
      .sck_i       (sck_i),
      .sdi_i       (sdi_i),
      .load_i      (load_word),
      .sdo_o       (sdo_o),
      .sdo_en_o    (sdo_en_o),
      .cfg_o       (cfg_pend),
      .short_o     (short_frame),
      .hi_clk_o    (hi_clk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q   <= '0;
         result_q <= '0;
         sleep_q  <= 1'b0;
         inval_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (conv_rise) held_q <= code;
         if (fin) begin
            result_q <= held_q;
         end else if (abort_now) begin
            result_q <= '0;
         end
         if (fin) begin
            sleep_q <= 1'b1;
         end else if (conv_fall) begin
            sleep_q <= 1'b0;
         end
         if (conv_fall) inval_q <= busy;
         if (conv_fall) begin
            err_q <= 1'b0;
         end else if (short_frame || hi_clk) begin
            err_q <= 1'b1;
         end
      end
   end

   assign busy_o         = busy;
   assign sleep_o        = sleep_q;
   assign word_invalid_o = inval_q;
   assign proto_err_o    = err_q;

   // R2
   sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_q |-> !busy);

   // R3
   inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inval_q) |-> $past(busy));

   // R8
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(conv_fall) |-> !err_q);

endmodule

// File: tb/adc_serial_model_bench.sv
module adc_serial_model_bench;

   localparam int W  = 16;
   localparam int NC = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         conv = 1'b0;
   logic         sck = 1'b0;
   logic         sdi = 1'b0;
   logic [W-1:0] a0 = '0;
   logic [W-1:0] a1 = '0;
   logic         sdo, sdo_en, busy, sleep, inval, perr;

   adc_serial_model #(.DATA_W(W), .CONV_CYCLES(NC)) u_adc_serial_model (
      .clk            (clk),
      .rst_n          (rst_n),
      .conv_i         (conv),
      .sck_i          (sck),
      .sdi_i          (sdi),
      .ain0_i         (a0),
      .ain1_i         (a1),
      .sdo_o          (sdo),
      .sdo_en_o       (sdo_en),
      .busy_o         (busy),
      .sleep_o        (sleep),
      .word_invalid_o (inval),
      .proto_err_o    (perr)
   );

   always #4 clk = ~clk;

   int           checks = 0;
   int           errors = 0;
   logic [1:0]   pend = 2'b10;
   logic [W-1:0] exp_word = '0;
   logic         exp_inval = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [1:0] c, input logic [W-1:0] x0, input logic [W-1:0] x1);
      logic [W-1:0] p, m;
      p = c[0] ? x1 : x0;
      m = c[0] ? x0 : x1;
      if (c[1]) return p;
      return (p >= m) ? p - m : '0;
   endfunction

   task automatic convert(input logic [W-1:0] x0, input logic [W-1:0] x1, input int hold,
                          input bit poke, input bit exp_err);
      @(negedge clk);
      a0 = x0; a1 = x1; conv = 1'b1;
      @(negedge clk);
      chk(sdo_en == 1'b0, "R1 enable off while strobe high", 32'(sdo_en), 32'd0);
      chk(busy == 1'b1, "R2 busy after strobe rise", 32'(busy), 32'd1);
      if (poke) begin
         sck = 1'b1; @(negedge clk); sck = 1'b0;
         repeat (hold - 2) @(negedge clk);
      end else begin
         repeat (hold - 1) @(negedge clk);
      end
      if (hold > NC + 1) begin
         chk(sleep == 1'b1, "R2 sleep after conversion", 32'(sleep), 32'd1);
         chk(busy == 1'b0, "R2 busy ends", 32'(busy), 32'd0);
         exp_word  = model(pend, x0, x1);
         exp_inval = 1'b0;
      end else begin
         exp_word  = '0;
         exp_inval = 1'b1;
      end
      chk(perr == exp_err, "R8 protocol flag", 32'(perr), 32'(exp_err));
   endtask

   task automatic frame(input logic [1:0] c, input int nclk);
      logic [W-1:0] word;
      @(negedge clk);
      conv = 1'b0;
      @(negedge clk);
      chk(sdo_en == 1'b1, "R1 enable on while strobe low", 32'(sdo_en), 32'd1);
      chk(busy == 1'b0, "R3 busy low in frame", 32'(busy), 32'd0);
      chk(inval == exp_inval, "R3 invalid flag", 32'(inval), 32'(exp_inval));
      chk(perr == 1'b0, "R8 flag cleared at fall", 32'(perr), 32'd0);
      chk(sleep == 1'b0, "R2 sleep cleared at fall", 32'(sleep), 32'd0);
      word = '0;
      for (int i = 0; i < nclk; i++) begin
         if (i < W) word[W-1-i] = sdo;
         else chk(sdo == 1'b0, "R6 zeros after last bit", 32'(sdo), 32'd0);
         sdi = (i < 2) ? c[1-i] : 1'($urandom);
         sck = 1'b1;
         @(negedge clk);
         sck = 1'b0;
         @(negedge clk);
      end
      if (nclk >= W) begin
         chk(sdo == 1'b0, "R6 zero after last fall", 32'(sdo), 32'd0);
         chk(word == exp_word, "R5 R7 shifted word", 32'(word), 32'(exp_word));
      end
      if (nclk >= 2) pend = c;
   endtask

   initial begin
      void'($urandom(32'd1865));
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy == 1'b0, "R9 busy reset", 32'(busy), 32'd0);
      chk(sleep == 1'b0, "R9 sleep reset", 32'(sleep), 32'd0);
      chk(perr == 1'b0, "R9 error reset", 32'(perr), 32'd0);
      chk(inval == 1'b0, "R9 invalid reset", 32'(inval), 32'd0);
      chk(sdo_en == 1'b0, "R9 enable reset", 32'(sdo_en), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 default single-ended input 0; write diff select 0
      convert(16'h3A5C, 16'h0F0F, NC + 3, 1'b0, 1'b0);
      chk(exp_word == 16'h3A5C, "R9 default setting", 32'(exp_word), 32'h3A5C);
      frame(2'b00, W);
      // R7 full-span difference
      convert(16'hFFFF, 16'h0000, NC + 3, 1'b0, 1'b0);
      frame(2'b01, W);
      // R7 negative difference clamps
      convert(16'h8000, 16'h1234, NC + 3, 1'b0, 1'b0);
      frame(2'b11, W);
      // R6 extra clocks, single-ended input 1
      convert(16'h1111, 16'hBEEF, NC + 3, 1'b0, 1'b0);
      frame(2'b10, W + 4);
      // R3 aborted conversion, setting still taken
      convert(16'h5555, 16'hAAAA, 4, 1'b0, 1'b0);
      frame(2'b11, W);
      convert(16'h0001, 16'hC001, NC + 3, 1'b0, 1'b0);
      frame(2'b10, W);
      // R8 short frame
      convert(16'h2222, 16'h3333, NC + 3, 1'b0, 1'b0);
      frame(2'b10, 8);
      convert(16'h4444, 16'h5555, NC + 3, 1'b0, 1'b1);
      frame(2'b01, W);
      // R8 shift clock while strobe high
      convert(16'h7777, 16'h6666, NC + 3, 1'b1, 1'b1);
      frame(2'b00, W);
      // random frames: R4 R5 R7
      for (int k = 0; k < 30; k++) begin
         logic [W-1:0] r0, r1;
         r0 = W'($urandom);
         r1 = (k % 7 == 0) ? r0 : W'($urandom);
         convert(r0, r1, NC + 3, 1'b0, 1'b0);
         frame(2'($urandom), W + int'($urandom % 3));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule